// File: doc/BRIEF.md
# Shared Work-RAM Bank Allocator

This block holds a 32 KiB shared work RAM, built as two synchronous 16 KiB halves. It places that RAM into the address windows of two 32-bit CPU ports, a main port and a secondary port. A 2-bit partition mode sets which halves each port can reach and how each port's 32 KiB window mirrors them. In one mode the secondary port does not reach the shared RAM at all. Its accesses are passed instead to an external private RAM interface.

Only the main port can change the mode, through a control word on its I/O path. The secondary port reads the mode back through a status word on its own I/O path. Each port window repeats across the whole port address space, because address bits above bit 14 are not decoded. The partition never gives one half to both ports at once, so the block has no arbiter.

Top module: `wram_bank_alloc`

## Requirements
- R1: After reset the partition mode is 0, so a status read returns 0.
- R2: A main I/O write to the word at byte offset 0x244, with byte enable bit 3 set, loads bits 25:24 of the written data into the mode. A write to any other offset, or a write with byte enable bit 3 clear, leaves the mode unchanged.
- R3: A secondary I/O read of the word at byte offset 0x240 returns the mode in bits 9:8 and zeros in all other bits. A read at any other offset returns 0. The read data is valid one cycle after the request.
- R4: In mode 0 the main port reaches the full 32 KiB linearly, with address bit 14 selecting the half. The secondary port is routed to the private RAM interface, with word address bits 14:2, and its read data comes from that interface.
- R5: In mode 1 the secondary port reaches half 0 and the main port reaches half 1. Each half is mirrored twice across its port's window.
- R6: In mode 2 the secondary port reaches half 1 and the main port reaches half 0. Each half is mirrored twice across its port's window.
- R7: In mode 3 the secondary port reaches the full 32 KiB linearly, with bit 14 selecting the half. Main-port writes are dropped, and main-port reads return 0.
- R8: Writes honour the four byte enables, where bit i covers data bits 8i+7:8i. Bytes that are not enabled keep their old value.
- R9: Port address bits above bit 14, and address bits 1:0, have no effect on which word is reached.
- R10: A port read returns its data with rvalid high exactly one cycle after the request. Writes raise no rvalid.
- R11: A mode change applies from the cycle after the control write. An access issued in the same cycle as that write uses the old mode.
- R12: A half is never driven by both ports in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_req_i | input | 1 | Main port request |
| a_we_i | input | 1 | Main port write (1) / read (0) |
| a_be_i | input | 4 | Main port byte enables |
| a_addr_i | input | 32 | Main port byte address |
| a_wdata_i | input | 32 | Main port write data |
| a_rdata_o | output | 32 | Main port read data |
| a_rvalid_o | output | 1 | Main port read data valid |
| a_io_we_i | input | 1 | Main I/O write strobe |
| a_io_addr_i | input | 16 | Main I/O byte offset |
| a_io_be_i | input | 4 | Main I/O byte enables |
| a_io_wdata_i | input | 32 | Main I/O write data |
| b_req_i | input | 1 | Secondary port request |
| b_we_i | input | 1 | Secondary port write (1) / read (0) |
| b_be_i | input | 4 | Secondary port byte enables |
| b_addr_i | input | 32 | Secondary port byte address |
| b_wdata_i | input | 32 | Secondary port write data |
| b_rdata_o | output | 32 | Secondary port read data |
| b_rvalid_o | output | 1 | Secondary port read data valid |
| b_io_req_i | input | 1 | Secondary I/O read request |
| b_io_addr_i | input | 16 | Secondary I/O byte offset |
| b_io_rdata_o | output | 32 | Secondary I/O read data |
| b_io_rvalid_o | output | 1 | Secondary I/O read valid |
| b_priv_req_o | output | 1 | Private RAM request |
| b_priv_we_o | output | 1 | Private RAM write |
| b_priv_be_o | output | 4 | Private RAM byte enables |
| b_priv_addr_o | output | 13 | Private RAM word address |
| b_priv_wdata_o | output | 32 | Private RAM write data |
| b_priv_rdata_i | input | 32 | Private RAM read data, one cycle after request |

## Verification
Two things can fall in the same cycle. The first is a control write that changes the mode while either port has a RAM access in flight. The second is a pair of accesses from both ports to the two halves in modes 1 and 2. The bench drives random traffic on both ports every cycle and mixes in random mode writes. For each cycle it predicts the route and data from the mode held before that cycle's control write. Each half and the private RAM are modelled on their own, so an access sent to the wrong half, or decoded under the wrong mode, shows up as a data mismatch on a later read.

// File: rtl/wram_pkg.sv
package wram_pkg;
  typedef enum logic [1:0] {
    MODE_MAIN_ALL = 2'd0,
    MODE_SPLIT_LO = 2'd1,
    MODE_SPLIT_HI = 2'd2,
    MODE_SUB_ALL  = 2'd3
  } wram_mode_e;

  typedef enum logic [1:0] {
    RT_NONE = 2'd0,
    RT_H0   = 2'd1,
    RT_H1   = 2'd2,
    RT_PRIV = 2'd3
  } wram_route_e;

  localparam int unsigned DATA_W = 32;
  localparam int unsigned NBYTES = DATA_W / 8;
endpackage

// File: rtl/wram_mode_ctrl.sv
module wram_mode_ctrl
  import wram_pkg::*;
#(
  parameter int unsigned IO_AW    = 16,
  parameter logic [15:0] CTRL_OFS = 16'h0244,
  parameter logic [15:0] STAT_OFS = 16'h0240,
  parameter int unsigned MODE_LSB = 24,
  parameter int unsigned STAT_LSB = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [IO_AW-1:0]  wr_addr_i,
  input  logic [NBYTES-1:0] wr_be_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_req_i,
  input  logic [IO_AW-1:0]  rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o,
  output wram_mode_e        mode_o
);
  localparam int unsigned MODE_BYTE = MODE_LSB / 8;

  logic ctrl_hit, stat_hit, load;
  assign ctrl_hit = wr_addr_i[IO_AW-1:2] == CTRL_OFS[IO_AW-1:2];
  assign stat_hit = rd_addr_i[IO_AW-1:2] == STAT_OFS[IO_AW-1:2];
  assign load     = wr_i && ctrl_hit && wr_be_i[MODE_BYTE];

  logic unused_io;
  assign unused_io = ^{wr_addr_i[1:0], rd_addr_i[1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_o <= MODE_MAIN_ALL;
    else if (load) mode_o <= wram_mode_e'(wr_data_i[MODE_LSB +: 2]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      rd_valid_o <= rd_req_i;
      rd_data_o  <= '0;
      if (rd_req_i && stat_hit) rd_data_o[STAT_LSB +: 2] <= mode_o;
    end
  end

  assert_mode_load_R2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> mode_o == $past(wr_data_i[MODE_LSB +: 2]));
  assert_mode_hold_R2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load |=> $stable(mode_o));
  assert_stat_clean_R3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> (rd_data_o[DATA_W-1:STAT_LSB+2] == '0 && rd_data_o[STAT_LSB-1:0] == '0));
endmodule

// File: rtl/wram_port_decode.sv
module wram_port_decode
  import wram_pkg::*;
#(
  parameter bit IS_MAIN = 1'b1
) (
  input  wram_mode_e mode_i,
  input  logic       addr_hi_i,
  output logic       hit_o,
  output logic       half_o,
  output logic       priv_o
);
  if (IS_MAIN) begin : g_main
    always_comb begin
      priv_o = 1'b0;
      hit_o  = 1'b1;
      half_o = 1'b0;
      unique case (mode_i)
        MODE_MAIN_ALL: half_o = addr_hi_i;
        MODE_SPLIT_LO: half_o = 1'b1;
        MODE_SPLIT_HI: half_o = 1'b0;
        MODE_SUB_ALL:  hit_o  = 1'b0;
        default:       hit_o  = 1'b0;
      endcase
    end
  end else begin : g_sub
    always_comb begin
      priv_o = 1'b0;
      hit_o  = 1'b1;
      half_o = 1'b0;
      unique case (mode_i)
        MODE_MAIN_ALL: begin hit_o = 1'b0; priv_o = 1'b1; end
        MODE_SPLIT_LO: half_o = 1'b0;
        MODE_SPLIT_HI: half_o = 1'b1;
        MODE_SUB_ALL:  half_o = addr_hi_i;
        default:       hit_o  = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/wram_half_ram.sv
module wram_half_ram
  import wram_pkg::*;
#(
  parameter int unsigned WORDS = 4096,
  localparam int unsigned AW   = $clog2(WORDS)
) (
  input  logic              clk_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [NBYTES-1:0] be_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem [WORDS];

  always_ff @(posedge clk_i) begin
    if (req_i) begin
      if (we_i) begin
        for (int i = 0; i < NBYTES; i++)
          if (be_i[i]) mem[addr_i][i*8 +: 8] <= wdata_i[i*8 +: 8];
      end else begin
        rdata_o <= mem[addr_i];
      end
    end
  end
endmodule

// File: rtl/wram_bank_alloc.sv
module wram_bank_alloc
  import wram_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned HALF_WORDS = 4096,
  parameter int unsigned IO_AW      = 16,
  parameter logic [15:0] CTRL_OFS   = 16'h0244,
  parameter logic [15:0] STAT_OFS   = 16'h0240,
  localparam int unsigned HALF_AW   = $clog2(HALF_WORDS),
  localparam int unsigned WIN_AW    = HALF_AW + 1,
  localparam int unsigned HALF_BIT  = HALF_AW + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              a_req_i,
  input  logic              a_we_i,
  input  logic [NBYTES-1:0] a_be_i,
  input  logic [ADDR_W-1:0] a_addr_i,
  input  logic [DATA_W-1:0] a_wdata_i,
  output logic [DATA_W-1:0] a_rdata_o,
  output logic              a_rvalid_o,
  input  logic              a_io_we_i,
  input  logic [IO_AW-1:0]  a_io_addr_i,
  input  logic [NBYTES-1:0] a_io_be_i,
  input  logic [DATA_W-1:0] a_io_wdata_i,
  input  logic              b_req_i,
  input  logic              b_we_i,
  input  logic [NBYTES-1:0] b_be_i,
  input  logic [ADDR_W-1:0] b_addr_i,
  input  logic [DATA_W-1:0] b_wdata_i,
  output logic [DATA_W-1:0] b_rdata_o,
  output logic              b_rvalid_o,
  input  logic              b_io_req_i,
  input  logic [IO_AW-1:0]  b_io_addr_i,
  output logic [DATA_W-1:0] b_io_rdata_o,
  output logic              b_io_rvalid_o,
  output logic              b_priv_req_o,
  output logic              b_priv_we_o,
  output logic [NBYTES-1:0] b_priv_be_o,
  output logic [WIN_AW-1:0] b_priv_addr_o,
  output logic [DATA_W-1:0] b_priv_wdata_o,
  input  logic [DATA_W-1:0] b_priv_rdata_i
);
  wram_mode_e mode;

  wram_mode_ctrl #(
    .IO_AW(IO_AW), .CTRL_OFS(CTRL_OFS), .STAT_OFS(STAT_OFS)
  ) u_mode (
    .clk_i, .rst_ni,
    .wr_i(a_io_we_i), .wr_addr_i(a_io_addr_i), .wr_be_i(a_io_be_i), .wr_data_i(a_io_wdata_i),
    .rd_req_i(b_io_req_i), .rd_addr_i(b_io_addr_i),
    .rd_data_o(b_io_rdata_o), .rd_valid_o(b_io_rvalid_o), .mode_o(mode)
  );

  logic a_hit, a_half, a_priv_unused;
  logic b_hit, b_half, b_priv;

  wram_port_decode #(.IS_MAIN(1'b1)) u_dec_a (
    .mode_i(mode), .addr_hi_i(a_addr_i[HALF_BIT]),
    .hit_o(a_hit), .half_o(a_half), .priv_o(a_priv_unused)
  );
  wram_port_decode #(.IS_MAIN(1'b0)) u_dec_b (
    .mode_i(mode), .addr_hi_i(b_addr_i[HALF_BIT]),
    .hit_o(b_hit), .half_o(b_half), .priv_o(b_priv)
  );

  logic unused_addr;
  assign unused_addr = ^{a_addr_i[ADDR_W-1:HALF_BIT+1], a_addr_i[1:0],
                         b_addr_i[ADDR_W-1:HALF_BIT+1], b_addr_i[1:0], a_priv_unused};

  logic a_go, b_go;
  assign a_go = a_req_i && a_hit;
  assign b_go = b_req_i && b_hit;

  logic [1:0] sel_a, sel_b;
  logic [DATA_W-1:0] h_rdata [2];

  for (genvar h = 0; h < 2; h++) begin : g_half
    logic              h_req, h_we;
    logic [NBYTES-1:0] h_be;
    logic [HALF_AW-1:0] h_addr;
    logic [DATA_W-1:0] h_wdata;

    assign sel_a[h] = a_go && (a_half == 1'(h));
    assign sel_b[h] = b_go && (b_half == 1'(h));
    assign h_req    = sel_a[h] || sel_b[h];
    assign h_we     = sel_a[h] ? a_we_i    : b_we_i;
    assign h_be     = sel_a[h] ? a_be_i    : b_be_i;
    assign h_addr   = sel_a[h] ? a_addr_i[HALF_BIT-1:2] : b_addr_i[HALF_BIT-1:2];
    assign h_wdata  = sel_a[h] ? a_wdata_i : b_wdata_i;

    wram_half_ram #(.WORDS(HALF_WORDS)) u_ram (
      .clk_i, .req_i(h_req), .we_i(h_we), .be_i(h_be),
      .addr_i(h_addr), .wdata_i(h_wdata), .rdata_o(h_rdata[h])
    );

    assert_half_excl_R12 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(sel_a[h] && sel_b[h]));
  end

  assign b_priv_req_o   = b_req_i && b_priv;
  assign b_priv_we_o    = b_we_i;
  assign b_priv_be_o    = b_be_i;
  assign b_priv_addr_o  = b_addr_i[HALF_BIT:2];
  assign b_priv_wdata_o = b_wdata_i;

  wram_route_e a_rt_q, b_rt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_rt_q <= RT_NONE; b_rt_q <= RT_NONE;
      a_rvalid_o <= 1'b0; b_rvalid_o <= 1'b0;
    end else begin
      a_rvalid_o <= a_req_i && !a_we_i;
      b_rvalid_o <= b_req_i && !b_we_i;
      a_rt_q <= !a_go ? RT_NONE : (a_half ? RT_H1 : RT_H0);
      b_rt_q <= b_priv ? RT_PRIV : (!b_go ? RT_NONE : (b_half ? RT_H1 : RT_H0));
    end
  end

  always_comb begin
    unique case (a_rt_q)
      RT_H0:   a_rdata_o = h_rdata[0];
      RT_H1:   a_rdata_o = h_rdata[1];
      default: a_rdata_o = '0;
    endcase
    unique case (b_rt_q)
      RT_H0:   b_rdata_o = h_rdata[0];
      RT_H1:   b_rdata_o = h_rdata[1];
      RT_PRIV: b_rdata_o = b_priv_rdata_i;
      default: b_rdata_o = '0;
    endcase
  end

  assert_main_blocked_R7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_SUB_ALL) |-> (sel_a == 2'b00));
  assert_sub_private_R4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_MAIN_ALL && b_req_i) |-> (b_priv_req_o && sel_b == 2'b00));
endmodule

// File: tb/wram_bank_alloc_tb_top.sv
`timescale 1ns/1ps
module wram_bank_alloc_tb_top;
  localparam int HW = 4096;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  always #2.5 clk_i = ~clk_i;

  logic a_req_i, a_we_i, a_io_we_i, b_req_i, b_we_i, b_io_req_i;
  logic [3:0] a_be_i, a_io_be_i, b_be_i, b_priv_be_o;
  logic [31:0] a_addr_i, a_wdata_i, a_rdata_o, a_io_wdata_i;
  logic [31:0] b_addr_i, b_wdata_i, b_rdata_o, b_io_rdata_o, b_priv_wdata_o, b_priv_rdata_i;
  logic [15:0] a_io_addr_i, b_io_addr_i;
  logic a_rvalid_o, b_rvalid_o, b_io_rvalid_o, b_priv_req_o, b_priv_we_o;
  logic [12:0] b_priv_addr_o;

  wram_bank_alloc dut_i (.*);

  logic [31:0] priv_mem [8192];
  always @(posedge clk_i) begin
    if (b_priv_req_o) begin
      if (b_priv_we_o) begin
        for (int i = 0; i < 4; i++)
          if (b_priv_be_o[i]) priv_mem[b_priv_addr_o][i*8 +: 8] <= b_priv_wdata_o[i*8 +: 8];
      end else b_priv_rdata_i <= priv_mem[b_priv_addr_o];
    end
  end

  logic [31:0] m_half [2][HW];
  logic [31:0] m_priv [8192];
  int mode_m = 0;
  int n_checks = 0, n_errors = 0;

  function automatic int route(int port, int md, logic [31:0] addr);
    if (port == 0) case (md)
      0: return addr[14] ? 2 : 1;
      1: return 2;
      2: return 1;
      default: return 0;
    endcase
    case (md)
      0: return 3;
      1: return 1;
      2: return 2;
      default: return addr[14] ? 2 : 1;
    endcase
  endfunction

  function automatic logic [31:0] mread(int r, logic [31:0] addr);
    case (r)
      1: return m_half[0][addr[13:2]];
      2: return m_half[1][addr[13:2]];
      3: return m_priv[addr[14:2]];
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] merge(logic [31:0] old, logic [31:0] d, logic [3:0] be);
    logic [31:0] n = old;
    for (int i = 0; i < 4; i++) if (be[i]) n[i*8 +: 8] = d[i*8 +: 8];
    return n;
  endfunction

  task automatic mwrite(int r, logic [31:0] addr, logic [31:0] d, logic [3:0] be);
    case (r)
      1: m_half[0][addr[13:2]] = merge(m_half[0][addr[13:2]], d, be);
      2: m_half[1][addr[13:2]] = merge(m_half[1][addr[13:2]], d, be);
      3: m_priv[addr[14:2]]    = merge(m_priv[addr[14:2]], d, be);
      default: ;
    endcase
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic string mtag(int md);
    case (md)
      0: return "R4";
      1: return "R5/R12";
      2: return "R6/R12";
      default: return "R7";
    endcase
  endfunction

  task automatic idle();
    a_req_i = 0; a_we_i = 0; a_be_i = 0; a_addr_i = 0; a_wdata_i = 0;
    b_req_i = 0; b_we_i = 0; b_be_i = 0; b_addr_i = 0; b_wdata_i = 0;
    a_io_we_i = 0; a_io_addr_i = 0; a_io_be_i = 0; a_io_wdata_i = 0;
    b_io_req_i = 0; b_io_addr_i = 0;
  endtask

  // drive values are already set; predict, advance one edge, compare
  task automatic run_cycle(string extra = "");
    logic ea_v, eb_v, es_v;
    logic [31:0] ea_d, eb_d, es_d;
    int ra, rb;
    string ta, tb;
    bit mchg;
    ra = route(0, mode_m, a_addr_i);
    rb = route(1, mode_m, b_addr_i);
    ea_v = a_req_i && !a_we_i; ea_d = mread(ra, a_addr_i);
    eb_v = b_req_i && !b_we_i; eb_d = mread(rb, b_addr_i);
    es_v = b_io_req_i;
    es_d = (b_io_addr_i[15:2] == 14'h0090) ? (32'(mode_m) << 8) : 32'h0;
    mchg = a_io_we_i && a_io_addr_i[15:2] == 14'h0091 && a_io_be_i[3];
    ta = mchg ? "R11" : mtag(mode_m);
    tb = ta;
    if (extra != "") begin ta = extra; tb = extra; end
    if (a_req_i && a_we_i) mwrite(ra, a_addr_i, a_wdata_i, a_be_i);
    if (b_req_i && b_we_i) mwrite(rb, b_addr_i, b_wdata_i, b_be_i);
    if (mchg) mode_m = int'(a_io_wdata_i[25:24]);
    @(posedge clk_i); #1;
    chk("R10 a_rvalid", 32'(a_rvalid_o), 32'(ea_v));
    chk("R10 b_rvalid", 32'(b_rvalid_o), 32'(eb_v));
    chk("R3 status valid", 32'(b_io_rvalid_o), 32'(es_v));
    if (ea_v) chk({ta, " main rdata"}, a_rdata_o, ea_d);
    if (eb_v) chk({tb, " sub rdata"}, b_rdata_o, eb_d);
    if (es_v) chk("R3 status data", b_io_rdata_o, es_d);
    @(negedge clk_i);
    idle();
  endtask

  task automatic set_mode(int md);
    a_io_we_i = 1; a_io_addr_i = 16'h0244; a_io_be_i = 4'hF;
    a_io_wdata_i = $urandom() & ~32'h0300_0000 | (32'(md) << 24);
    run_cycle();
  endtask

  task automatic read_status(string tag);
    b_io_req_i = 1; b_io_addr_i = 16'h0240;
    @(posedge clk_i); #1;
    chk({tag, " status"}, b_io_rdata_o, 32'(mode_m) << 8);
    @(negedge clk_i); idle();
  endtask

  task automatic rand_cycle(bit mode_flips);
    a_req_i = ($urandom_range(0, 3) != 0); a_we_i = $urandom_range(0, 1);
    a_be_i = $urandom(); a_addr_i = $urandom(); a_wdata_i = $urandom();
    b_req_i = ($urandom_range(0, 3) != 0); b_we_i = $urandom_range(0, 1);
    b_be_i = $urandom(); b_addr_i = $urandom(); b_wdata_i = $urandom();
    if ($urandom_range(0, 7) == 0) begin
      b_io_req_i = 1; b_io_addr_i = $urandom_range(0, 1) ? 16'h0240 : 16'($urandom());
    end
    if (mode_flips && $urandom_range(0, 15) == 0) begin
      a_io_we_i = 1; a_io_addr_i = 16'h0244 | 16'($urandom_range(0, 3));
      a_io_be_i = $urandom(); a_io_wdata_i = $urandom();
    end
    run_cycle();
  endtask

  initial begin
    #(200000 * 5);
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 8192; i++) begin priv_mem[i] = 0; m_priv[i] = 0; end
    idle();
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    // R1: reset state
    read_status("R1");
    chk("R1 a_rvalid idle", 32'(a_rvalid_o), 0);

    // R4: fill both halves linearly from main, private RAM from secondary
    for (int i = 0; i < 2 * HW; i++) begin
      a_req_i = 1; a_we_i = 1; a_be_i = 4'hF; a_addr_i = 32'(i) << 2; a_wdata_i = $urandom();
      b_req_i = 1; b_we_i = 1; b_be_i = 4'hF; b_addr_i = 32'(i) << 2; b_wdata_i = $urandom();
      run_cycle();
    end
    a_req_i = 1; a_addr_i = 32'h0000_4010; b_req_i = 1; b_addr_i = 32'h0000_4010;
    run_cycle("R4");

    // R8: partial byte write
    a_req_i = 1; a_we_i = 1; a_be_i = 4'b0101; a_addr_i = 32'h0000_0120; a_wdata_i = 32'hA1B2C3D4;
    run_cycle();
    a_req_i = 1; a_addr_i = 32'h0000_0120; run_cycle("R8");

    // R9: high and low address bits ignored
    a_req_i = 1; a_we_i = 1; a_be_i = 4'hF; a_addr_i = 32'hFFFF_8204; a_wdata_i = 32'h5A5A_1234;
    run_cycle();
    a_req_i = 1; a_addr_i = 32'h0123_0207; run_cycle("R9");
    b_req_i = 1; b_addr_i = 32'hABCD_4008; run_cycle("R9");

    // R2: writes that must not change the mode
    a_io_we_i = 1; a_io_addr_i = 16'h0240; a_io_be_i = 4'hF; a_io_wdata_i = 32'h0300_0000;
    run_cycle(); read_status("R2");
    a_io_we_i = 1; a_io_addr_i = 16'h0244; a_io_be_i = 4'b0111; a_io_wdata_i = 32'h0300_0000;
    run_cycle(); read_status("R2");
    set_mode(2); read_status("R2");

    // R11: access issued with the mode write sees the old mode
    set_mode(0);
    a_io_we_i = 1; a_io_addr_i = 16'h0244; a_io_be_i = 4'h8; a_io_wdata_i = 32'h0100_0000;
    a_req_i = 1; a_addr_i = 32'h0000_0040;
    run_cycle("R11");
    a_req_i = 1; a_addr_i = 32'h0000_0040; run_cycle("R11");

    // per-mode random traffic
    for (int md = 0; md < 4; md++) begin
      set_mode(md);
      read_status(mtag(md));
      for (int k = 0; k < 1500; k++) rand_cycle(1'b0);
    end
    // R7 directed: main write dropped, read zero; secondary sees it unchanged
    a_req_i = 1; a_we_i = 1; a_be_i = 4'hF; a_addr_i = 32'h0000_0300; a_wdata_i = 32'hDEAD_BEEF;
    run_cycle();
    a_req_i = 1; a_addr_i = 32'h0000_0300; b_req_i = 1; b_addr_i = 32'h0000_0300;
    run_cycle("R7");

    // random traffic with mode changes in flight
    for (int k = 0; k < 4000; k++) rand_cycle(1'b1);
    read_status("R11");

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule